// File: doc/BRIEF.md
# Partitioned-Table Bit-Plane FIR Filter

This block is a streaming finite impulse response filter that uses no multipliers. It holds a window of the most recent signed input samples and forms the sum of products between that window and a fixed coefficient set. The coefficient set is a parameter.

Before elaboration, coefficients equal to zero are dropped. The remaining taps are split into groups of uneven size. Each group owns a small table that holds every possible partial sum of its coefficients.

For every bit position of the samples, a group's table is addressed by that bit taken from each of the group's delayed samples. All bit positions are looked up in the same cycle, each through its own copy of the tables. Each bit-plane result is shifted by its position, and the sign plane is subtracted rather than added. The sum is carried at full precision and rounded once, at the end, to the output width.

The block accepts one sample per clock and delivers one result per clock through a valid/ready stream pair on each side. The whole pipeline advances only when the output register is empty or is being drained. The input ready therefore mirrors that condition.

When `m_valid` is high and `m_ready` is low, everything holds: the window does not move, `s_ready` is low, and `m_data` stays put. A parameter selects one of two builds:
- a two-stage build, for short latency;
- a deeply registered build, for timing.

In both builds the latency does not depend on the number of taps.

Top module: `dafir_top`

## Requirements
- R1: With the default coefficients {3,-9,0,21,-34,18,55,-120,211,400,211,-120,55,18,-34,21,0,-9,3}, applied as c[0] to the newest sample, each output equals floor((sum of c[i]*x[n-i] + 2^(RSH-1)) / 2^RSH), with RSH = 8. Window slots that have not yet received a sample since reset count as zero.
- R2: Input samples are 12-bit two's complement. The sign bit carries weight -2^11, so inputs of -2048 and -1 produce the exact R1 result.
- R3: With the default registered build, a sample accepted on a rising edge has its result in `m_data` with `m_valid` high after the 7th rising edge, counting the accepting edge as the first. The two-stage build takes 2 edges. No more than that many samples are ever in flight.
- R4: Exactly one output is produced for each accepted sample, in acceptance order. `m_valid` never rises without an accepted sample behind it.
- R5: `s_ready` is high whenever `m_valid` is low or `m_ready` is high, and low otherwise. While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold on the next cycle.
- R6: Cycles in which no sample is accepted (`s_valid` low, or `s_ready` low) do not move the sample window. The output stream depends only on the sequence of accepted samples.
- R7: Zero coefficients use no table address bits. An impulse of amplitude 256 followed by zeros yields exactly the 19 default coefficients in order, including 0 at positions 2 and 16.
- R8: After reset, `m_valid` is low and `s_ready` is high.
- R9: A full-scale pattern whose sample signs match the coefficient signs (+2047 / -2048) yields the exact R1 value without wrap-around, and so does its mirror pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input sample present |
| s_ready | output | 1 | Block can take a sample this cycle |
| s_data | input | DW (12) | Signed input sample |
| m_valid | output | 1 | Filtered result present |
| m_ready | input | 1 | Downstream takes the result this cycle |
| m_data | output | OW (16) | Rounded signed filter output |

## Verification
The assertions check the stream rules on every cycle:
- the ready/stall relation, and that a stalled result holds;
- that a result never appears without an accepted sample behind it;
- that the count of samples in flight never exceeds the pipeline depth.

The bench scenarios are the only thing that can show arithmetic correctness:
- the rounded convolution value;
- the negative weight of the sign plane;
- the skipped zero coefficients;
- full-scale sums without wrap;
- the exact first-result latency;
- that bubbles and stalls leave the window untouched.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  // Smallest signed width that holds every value in [lo, hi].
  function automatic int sbits(int lo, int hi);
    int w;
    w = 1;
    while ((hi > (2 ** (w - 1)) - 1) || (lo < -(2 ** (w - 1)))) w++;
    return w;
  endfunction

endpackage

// File: rtl/dafir_tapline.sv
module dafir_tapline #(
  parameter int DW = 12,
  parameter int N  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] taps [N]
);

  // taps[0] is the newest accepted sample; older samples move up one slot per accept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '{default: '0};
    end else if (shift) begin
      taps[0] <= din;
      for (int i = 1; i < N; i++) taps[i] <= taps[i-1];
    end
  end

endmodule

// File: rtl/dafir_grp_rom.sv
module dafir_grp_rom
  import dafir_pkg::*;
#(
  parameter int NTAPS       = 1,
  parameter int COEF [NTAPS] = '{default: 0},
  parameter int OFF         = 0,
  parameter int K           = 1,
  parameter int LW          = 8
) (
  input  logic [K-1:0]         addr,
  output logic signed [LW-1:0] data
);

  localparam int NENT = 2 ** K;

  // Tap index of the j-th nonzero coefficient.
  function automatic int nzp(int j);
    int c;
    c = 0;
    for (int i = 0; i < NTAPS; i++) begin
      if (COEF[i] != 0) begin
        if (c == j) return i;
        c++;
      end
    end
    return 0;
  endfunction

  // sel = 1: sum of the group's negative coefficients; otherwise sum of the positive ones.
  function automatic int side_sum(int sel);
    int s;
    s = 0;
    for (int j = 0; j < K; j++) begin
      if (sel == 1 && COEF[nzp(OFF + j)] < 0) s += COEF[nzp(OFF + j)];
      if (sel != 1 && COEF[nzp(OFF + j)] > 0) s += COEF[nzp(OFF + j)];
    end
    return s;
  endfunction

  // Entry width that exactly covers this group's partial-sum range.
  localparam int TW = sbits(side_sum(1), side_sum(0));

  typedef logic signed [TW-1:0] ent_t;
  typedef ent_t tbl_t [NENT];

  function automatic tbl_t build();
    tbl_t t;
    for (int a = 0; a < NENT; a++) begin
      int s;
      s = 0;
      for (int j = 0; j < K; j++) if (a[j]) s += COEF[nzp(OFF + j)];
      t[a] = ent_t'(s);
    end
    return t;
  endfunction

  localparam tbl_t TBL = build();

  assign data = LW'(TBL[addr]);

endmodule

// File: rtl/dafir_reduce.sv
module dafir_reduce #(
  parameter int DW   = 12,
  parameter int NGRP = 3,
  parameter int LW   = 12,
  parameter int AW   = 25,
  parameter int OW   = 16,
  parameter int RSH  = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic signed [LW-1:0] pv [DW][NGRP],
  output logic signed [OW-1:0] y
);

  localparam int NLEV = $clog2(DW);
  localparam logic signed [AW-1:0] HALF = AW'(2 ** (RSH - 1));

  // Stage holding the table outputs.
  logic signed [LW-1:0] pq [DW][NGRP];

  if (PIPE) begin : g_preg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pq <= '{default: '0};
      else if (adv) pq <= pv;
    end
  end else begin : g_pcomb
    always_comb pq = pv;
  end

  // Level 0: one weighted value per bit-plane. Levels 1..NLEV: pairwise sums.
  for (genvar l = 0; l <= NLEV; l++) begin : g_lv
    logic signed [AW-1:0] c [DW];
    logic signed [AW-1:0] q [DW];

    if (l == 0) begin : g_src
      always_comb begin : p_weight
        logic signed [AW-1:0] acc;
        for (int r = 0; r < DW; r++) begin
          acc = '0;
          for (int g = 0; g < NGRP; g++) acc = acc + AW'(pq[r][g]);
          acc = acc <<< r;
          c[r] = (r == DW - 1) ? -acc : acc;
        end
      end
    end else begin : g_add
      always_comb begin
        for (int i = 0; i < DW; i++) begin
          c[i] = '0;
          if (2 * i < DW)     c[i] = g_lv[l-1].q[2*i];
          if (2 * i + 1 < DW) c[i] = c[i] + g_lv[l-1].q[2*i+1];
        end
      end
    end

    if (PIPE && (l < NLEV)) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '{default: '0};
        else if (adv) q <= c;
      end
    end else begin : g_wire
      always_comb q = c;
    end
  end

  logic signed [AW-1:0] rs;
  assign rs = g_lv[NLEV].q[0] + HALF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   y <= '0;
    else if (adv) y <= OW'(rs >>> RSH);
  end

endmodule

// File: rtl/dafir_top.sv
module dafir_top
  import dafir_pkg::*;
#(
  parameter int DW           = 12,
  parameter int NTAPS        = 19,
  parameter int COEF [NTAPS] = '{3, -9, 0, 21, -34, 18, 55, -120, 211, 400,
                                 211, -120, 55, 18, -34, 21, 0, -9, 3},
  parameter int NGRP         = 3,
  parameter int GSIZE [NGRP] = '{6, 6, 5},
  parameter int OW           = 16,
  parameter int RSH          = 8,
  parameter bit PIPE         = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_data,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic signed [OW-1:0] m_data
);

  function automatic int nzp(int j);
    int c;
    c = 0;
    for (int i = 0; i < NTAPS; i++) begin
      if (COEF[i] != 0) begin
        if (c == j) return i;
        c++;
      end
    end
    return 0;
  endfunction

  function automatic int grp_off(int g);
    int s;
    s = 0;
    for (int i = 0; i < g; i++) s += GSIZE[i];
    return s;
  endfunction

  function automatic int abs_sum();
    int s;
    s = 0;
    for (int i = 0; i < NTAPS; i++) s += (COEF[i] < 0) ? -COEF[i] : COEF[i];
    return s;
  endfunction

  localparam int LW   = sbits(-abs_sum(), abs_sum());
  localparam int AW0  = LW + DW + 1;
  localparam int AW   = (AW0 > RSH + OW) ? AW0 : RSH + OW;
  localparam int NLEV = $clog2(DW);
  localparam int LAT  = PIPE ? NLEV + 3 : 2;

  logic adv;
  logic [LAT:1] vp;
  logic signed [DW-1:0] taps [NTAPS];
  logic signed [LW-1:0] pv [DW][NGRP];

  assign adv     = !m_valid || m_ready;
  assign s_ready = adv;
  assign m_valid = vp[LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vp <= '0;
    else if (adv) vp <= {vp[LAT-1:1], s_valid};
  end

  dafir_tapline #(.DW(DW), .N(NTAPS)) u_taps (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (s_valid && adv),
    .din   (s_data),
    .taps  (taps)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int K   = GSIZE[g];
    localparam int OFF = grp_off(g);
    logic [K-1:0] ad [DW];

    for (genvar j = 0; j < K; j++) begin : g_bit
      localparam int TI = nzp(OFF + j);
      for (genvar r = 0; r < DW; r++) begin : g_pl
        assign ad[r][j] = taps[TI][r];
      end
    end

    for (genvar r = 0; r < DW; r++) begin : g_rom
      dafir_grp_rom #(
        .NTAPS (NTAPS),
        .COEF  (COEF),
        .OFF   (OFF),
        .K     (K),
        .LW    (LW)
      ) u_rom (
        .addr (ad[r]),
        .data (pv[r][g])
      );
    end
  end

  dafir_reduce #(
    .DW   (DW),
    .NGRP (NGRP),
    .LW   (LW),
    .AW   (AW),
    .OW   (OW),
    .RSH  (RSH),
    .PIPE (PIPE)
  ) u_red (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .pv    (pv),
    .y     (m_data)
  );

endmodule

// File: rtl/dafir_chk.sv
module dafir_chk #(
  parameter int LAT = 7,
  parameter int OW  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [OW-1:0] m_data
);

  localparam int CWD = $clog2(LAT + 2) + 1;

  logic [CWD-1:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + CWD'(s_valid && s_ready) - CWD'(m_valid && m_ready);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R5
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready); // R5
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready); // R5
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (inflight != '0)); // R4
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CWD'(LAT)); // R3

endmodule

bind dafir_top dafir_chk #(.LAT(LAT), .OW(OW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data)
);

// File: tb/tb_dafir_top.sv
module tb_dafir_top;

  localparam int DW  = 12;
  localparam int OW  = 16;
  localparam int RSH = 8;
  localparam int LAT = 7;
  localparam int NT  = 19;
  localparam int CF [NT] = '{3, -9, 0, 21, -34, 18, 55, -120, 211, 400,
                             211, -120, 55, 18, -34, 21, 0, -9, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic m_ready = 1'b0;
  logic s_ready, m_valid;
  logic signed [DW-1:0] s_data = '0;
  logic signed [OW-1:0] m_data;

  always #4 clk = ~clk;

  dafir_top dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data)
  );

  int nchk = 0, nfail = 0, cyc = 0, nacc = 0;
  int hist [8192];
  int exq [$];
  string tag = "R1";
  bit stall_prev = 1'b0;
  int stall_data = 0;
  int first_in = -1, first_out = -1;

  function automatic int model(int n);
    int acc;
    acc = 0;
    for (int i = 0; i < NT; i++) if (n - i >= 0) acc += CF[i] * hist[n-i];
    return (acc + (1 << (RSH - 1))) >>> RSH;
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(bit sv, int sd, bit mr);
    @(negedge clk);
    cyc++;
    s_valid = sv;
    s_data  = DW'(sd);
    m_ready = mr;
    #1;
    if (stall_prev) begin
      chk("R5", int'(m_valid), 1);
      chk("R5", int'(m_data), stall_data);
    end
    stall_prev = m_valid && !m_ready;
    if (m_valid && !m_ready) begin
      stall_data = int'(m_data);
      chk("R5", int'(s_ready), 0);
    end
    if (m_valid && m_ready) begin
      if (first_out < 0) first_out = cyc;
      if (exq.size() == 0) chk("R4", 1, 0);
      else chk(tag, int'(m_data), exq.pop_front());
    end
    if (sv && s_ready) begin
      hist[nacc] = sd;
      exq.push_back(model(nacc));
      nacc++;
      if (first_in < 0) first_in = cyc;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk("R8", int'(m_valid), 0);
    chk("R8", int'(s_ready), 1);
    rst_n = 1'b1;

    // R7: impulse of 2^RSH returns every coefficient, zeros included; R3 latency.
    tag = "R7";
    step(1, 256, 1);
    repeat (NT) step(1, 0, 1);
    repeat (LAT + 2) step(0, 0, 1);
    chk("R3", first_out - first_in, LAT);

    // R9: full-scale patterns aligned with the coefficient signs, and their mirror.
    tag = "R9";
    for (int k = 0; k < NT; k++)
      step(1, (CF[NT-1-k] > 0) ? 2047 : ((CF[NT-1-k] < 0) ? -2048 : 0), 1);
    for (int k = 0; k < NT; k++)
      step(1, (CF[NT-1-k] > 0) ? -2048 : ((CF[NT-1-k] < 0) ? 2047 : 0), 1);

    // R2: most negative input held, then alternating sign-heavy values.
    tag = "R2";
    repeat (NT + 2) step(1, -2048, 1);
    for (int k = 0; k < 2 * NT; k++) step(1, (k % 2) ? -1 : -2048, 1);
    repeat (LAT + 2) step(0, 0, 1);

    // R1 R6: random samples with bubbles on the input and stalls on the output.
    tag = "R1 R6";
    for (int k = 0; k < 3000; k++)
      step(($urandom % 10) < 7, int'($urandom_range(4095)) - 2048, ($urandom % 10) < 7);

    // R4: drain; every accepted sample produced exactly one result.
    tag = "R4";
    repeat (LAT + 4) step(0, 0, 1);
    chk("R4", exq.size(), 0);
    chk("R4", int'(m_valid), 0);
    finish_run();
  end

endmodule